// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bit Receiver

This block takes data bits from one asynchronous input line on which every bit begins with a rising edge. The width of the high pulse carries the value. A long high pulse of about 0.8 of the bit period means 1. A short high pulse of about 0.2 of the bit period means 0. No clock travels with the data. The receiver times a fixed delay from each rising edge and then samples the line. The delay is about half of the nominal bit period. At that point a one is still high and a zero has already fallen.

The input first passes through a two-flop synchronizer and a rising-edge detector. A delay counter then decides when to sample. Each sampled bit shifts into the received word, most significant bit first, and a bit counter goes up by one. An idle counter watches for a long stretch with no rising edge. When that happens, a one-cycle frame-end pulse closes the frame. The word and the count stay visible until the first bit of the next frame is latched.

The sample delay and the timeout are given in system-clock cycles. With the 50 MHz defaults, 357 cycles sits inside the 0.2 to 0.8 window for any bit rate from 60 to 80 kHz. The timeout of 800000 cycles equals 16 ms. The timeout must be larger than the sample delay.

Top module: `pulse_bit_rx`

## Requirements
- R1: While reset is held and just after it is released, `rx_word` and `bit_count` are 0, and `bit_valid` and `frame_end` are low.
- R2: A rising edge on `line_in` produces a one-cycle `bit_valid` pulse exactly SAMPLE_DLY+3 rising clock edges after the edge. This counts two synchronizer flops and one edge register.
- R3: The decoded bit is 1 when the line is still high at the sample point, as for a pulse high for 0.8 of the bit period. It is 0 when the line is already low there, as for a pulse high for 0.2 of the bit period.
- R4: Bits enter most significant first. Each new bit goes into `rx_word[0]` and earlier bits move up one place, so after n bits (n <= WORD_W) the first bit received is at `rx_word[n-1]`.
- R5: `bit_count` goes up by one for each bit and stops at WORD_W. After more than WORD_W bits, `rx_word` holds the last WORD_W bits.
- R6: A rising edge that arrives while a bit is waiting to be sampled is ignored. It makes no extra bit and does not shift the sample point.
- R7: `frame_end` is a one-cycle pulse. It comes TIMEOUT+3 clock edges after the last accepted rising edge, and only when no further accepted edge arrives in between.
- R8: After `frame_end`, `rx_word` and `bit_count` hold their values until the first bit of the next frame is sampled. That bit sets `bit_count` to 1 and `rx_word` to the bit alone.
- R9: No `frame_end` is produced while the line stays idle with no bit received since reset or since the previous frame end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | Asynchronous pulse-width-encoded data line |
| rx_word | output | WORD_W | Received bits, most recent bit in bit 0 |
| bit_count | output | $clog2(WORD_W+1) | Bits received in the current frame, saturating at WORD_W |
| bit_valid | output | 1 | One-cycle pulse when a bit has been latched |
| frame_end | output | 1 | One-cycle pulse when the idle timeout closes the frame |

## Verification
The bound assertions check, on every cycle, the properties that involve only the outputs:
- both pulses last a single cycle;
- `bit_count` never goes past WORD_W;
- the word and the count stay still except in a `bit_valid` cycle;
- on every plain increment the old word appears shifted up by one place;
- a frame end never coincides with a bit.

Only the bench scenarios can show the rest:
- the exact delays from a line edge to `bit_valid` and to `frame_end`;
- how short and long pulses decode;
- that a second edge inside a pending bit is ignored;
- saturation, and holding the word between frames;
- that a quiet line never produces a spurious frame end.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  // Width of a counter that must hold the values 0..n inclusive.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pbr_sync.sv
// Two-flop synchronizer followed by a rising-edge detector.
module pbr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o
);

  logic meta_q, stab_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  always_comb begin
    level_o = stab_q;
    rise_o  = stab_q & ~prev_q;
  end

endmodule

// File: rtl/pbr_bit_timer.sv
// Starts on an edge when idle and strobes the sample point SAMPLE_DLY cycles later.
module pbr_bit_timer #(
  parameter int unsigned SAMPLE_DLY = 357
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  output logic start_o,
  output logic sample_o
);

  localparam int unsigned DW = (SAMPLE_DLY > 2) ? $clog2(SAMPLE_DLY) : 1;
  localparam logic [DW-1:0] LAST = DW'(SAMPLE_DLY - 1);

  logic          busy_q, busy_n;
  logic [DW-1:0] cnt_q, cnt_n;

  always_comb begin
    start_o  = rise_i & ~busy_q;
    sample_o = busy_q & (cnt_q == LAST);
    busy_n   = busy_q;
    cnt_n    = cnt_q;
    if (start_o) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (sample_o) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/pbr_shifter.sv
// Shift register, saturating bit counter and new-frame flag.
module pbr_shifter
  import pbr_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CW = cnt_bits(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              close_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CW-1:0]     count_o,
  output logic              valid_o
);

  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [WORD_W-1:0] word_q, word_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              fresh_q, fresh_n;
  logic              valid_q;

  always_comb begin
    word_n  = word_q;
    cnt_n   = cnt_q;
    fresh_n = fresh_q;
    if (sample_i) begin
      fresh_n = 1'b0;
      if (fresh_q) begin
        word_n = {{(WORD_W-1){1'b0}}, bit_i};
        cnt_n  = CW'(1);
      end else begin
        word_n = {word_q[WORD_W-2:0], bit_i};
        cnt_n  = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
      end
    end
    if (close_i) fresh_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      cnt_q   <= '0;
      fresh_q <= 1'b1;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_n;
      cnt_q   <= cnt_n;
      fresh_q <= fresh_n;
      valid_q <= sample_i;
    end
  end

  assign word_o  = word_q;
  assign count_o = cnt_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/pbr_idle.sv
// Counts quiet cycles after an accepted edge; ends the frame at TIMEOUT.
module pbr_idle #(
  parameter int unsigned TIMEOUT = 800000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic end_o
);

  localparam int unsigned TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  logic          act_q, act_n;
  logic [TW-1:0] cnt_q, cnt_n;
  logic          end_q, end_n;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    end_n = 1'b0;
    if (start_i) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_n = 1'b0;
        end_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      end_q <= 1'b0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      end_q <= end_n;
    end
  end

  assign end_o = end_q;

endmodule

// File: rtl/pulse_bit_rx.sv
// Top: pulse-width single-wire bit receiver.
module pulse_bit_rx
  import pbr_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned SAMPLE_DLY = 357,
  parameter int unsigned TIMEOUT    = 800000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        line_in,
  output logic [WORD_W-1:0]           rx_word,
  output logic [cnt_bits(WORD_W)-1:0] bit_count,
  output logic                        bit_valid,
  output logic                        frame_end
);

  logic [1:0] rst_sync_q;
  logic       srst_n;
  logic       level, rise, start, sample;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  pbr_sync u_sync (
    .clk     (clk),
    .rst_n   (srst_n),
    .line_i  (line_in),
    .level_o (level),
    .rise_o  (rise)
  );

  pbr_bit_timer #(.SAMPLE_DLY(SAMPLE_DLY)) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .rise_i   (rise),
    .start_o  (start),
    .sample_o (sample)
  );

  pbr_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (srst_n),
    .sample_i (sample),
    .bit_i    (level),
    .close_i  (frame_end),
    .word_o   (rx_word),
    .count_o  (bit_count),
    .valid_o  (bit_valid)
  );

  pbr_idle #(.TIMEOUT(TIMEOUT)) u_idle (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (start),
    .end_o   (frame_end)
  );

endmodule

// File: rtl/pbr_checker.sv
module pbr_checker #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CW = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_valid,
  input logic              frame_end,
  input logic [WORD_W-1:0] rx_word,
  input logic [CW-1:0]     bit_count
);

  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  a_r7_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  a_r7_end_not_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !bit_valid);

  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= CW'(WORD_W));

  a_r8_hold_between_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> ($stable(rx_word) && $stable(bit_count)));

  a_r4_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && $past(bit_count) != '0 && bit_count == $past(bit_count) + CW'(1))
      |-> rx_word[WORD_W-1:1] == $past(rx_word[WORD_W-2:0]));

  a_r8_fresh_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_count == CW'(1)) |-> rx_word[WORD_W-1:1] == '0);

endmodule

bind pulse_bit_rx pbr_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_valid (bit_valid),
  .frame_end (frame_end),
  .rx_word   (rx_word),
  .bit_count (bit_count)
);

// File: tb/pulse_bit_rx_bench.sv
module pulse_bit_rx_bench;
  localparam int W  = 8;
  localparam int D  = 20;
  localparam int T  = 100;
  localparam int P  = 50;
  localparam int H1 = 40;
  localparam int H0 = 10;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line = 1'b0;
  logic [W-1:0]  rx_word;
  logic [CW-1:0] bit_count;
  logic          bit_valid, frame_end;

  always #10 clk = ~clk;

  pulse_bit_rx #(.WORD_W(W), .SAMPLE_DLY(D), .TIMEOUT(T)) u_pulse_bit_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line),
    .rx_word(rx_word), .bit_count(bit_count),
    .bit_valid(bit_valid), .frame_end(frame_end)
  );

  int checks = 0;
  int fails  = 0;
  int n_end  = 0;

  always @(negedge clk) if (frame_end) n_end++;

  // {bit count, data sent from bit n-1 down to bit 0}
  localparam logic [11:0] VEC [6] = '{
    {4'd8, 8'hA5}, {4'd8, 8'h00}, {4'd8, 8'hFF},
    {4'd1, 8'h01}, {4'd3, 8'h05}, {4'd5, 8'h0C}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    int h;
    h = b ? H1 : H0;
    line = 1'b1;
    repeat (h) @(negedge clk);
    line = 1'b0;
    repeat (P - h) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic wait_end(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (frame_end) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic seen;
    int tv, te, elen;
    logic [W-1:0]  hw;
    logic [CW-1:0] hc;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 word in reset", rx_word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 word", rx_word, 0);
    chk("R1 count", bit_count, 0);
    chk("R1 bit_valid", bit_valid, 0);
    chk("R1 frame_end", frame_end, 0);

    // R2 / R7 latency from one rising edge, single long bit
    tv = 0; te = 0; elen = 0;
    line = 1'b1;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (bit_valid && tv == 0) tv = k;
      if (frame_end) begin
        elen++;
        if (te == 0) te = k;
      end
      if (k == H1) line = 1'b0;
    end
    chk("R2 sample latency", tv, D + 3);
    chk("R7 frame_end latency", te, T + 3);
    chk("R7 frame_end width", elen, 1);
    chk("R3 long pulse is 1", rx_word, 1);

    // table of frames: R3 R4 R5 R7
    foreach (VEC[i]) begin
      send_bits({8'h00, VEC[i][7:0]}, int'(VEC[i][11:8]));
      wait_end(seen);
      chk("R7 frame closed", seen, 1);
      chk("R4 word", rx_word, VEC[i][7:0]);
      chk("R5 count", bit_count, VEC[i][11:8]);
      @(negedge clk);
    end

    // R6 extra rising edge inside a pending bit is ignored
    line = 1'b1; repeat (5) @(negedge clk);
    line = 1'b0; repeat (3) @(negedge clk);
    line = 1'b1; repeat (5) @(negedge clk);
    line = 1'b0; repeat (P - 13) @(negedge clk);
    send_bit(1'b1);
    wait_end(seen);
    chk("R6 count with glitch", bit_count, 2);
    chk("R6 word with glitch", rx_word, 1);
    @(negedge clk);

    // R5 saturation: 10 bits into an 8-bit word
    send_bits(16'b11_0011_0101, 10);
    wait_end(seen);
    chk("R5 saturated count", bit_count, W);
    chk("R5 last bits kept", rx_word, 8'h35);
    @(negedge clk);

    // R8 hold after frame end
    hw = rx_word; hc = bit_count;
    repeat (60) @(negedge clk);
    chk("R8 word held", rx_word, hw);
    chk("R8 count held", bit_count, hc);

    // R8 first bit of next frame restarts (short pulse -> 0)
    line = 1'b1; repeat (H0) @(negedge clk);
    line = 1'b0;
    for (int i = 0; i < 40 && !bit_valid; i++) @(negedge clk);
    chk("R8 restart valid seen", bit_valid, 1);
    chk("R8 restart count", bit_count, 1);
    chk("R3 short pulse is 0", rx_word, 0);
    wait_end(seen);
    @(negedge clk);

    // R9 quiet line gives no frame end
    tv = n_end;
    repeat (400) @(negedge clk);
    chk("R9 no spurious frame_end", n_end, tv);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule